// File: doc/BRIEF.md
# Vector Length Control Registers

This block keeps the vector-length state of a scalar core that carries a variable-length vector extension. It holds a maximum vector length (MVL) register in an offset-by-one encoding, the current vector length (VL), and two element offsets that the execution pipeline advances while a vector instruction is in progress. A set-length request supplies a requested element count and a destination register index. The block clamps the count into the range from 1 to MVL, stores the result as VL, and returns it on a writeback port one clock later. A request whose destination is register 0 is dropped without trace.

Software reaches the state through a small CSR port with three registers. The first is the encoded MVL. The second is a read-only view of VL. The third is a packed state word that saves and restores MVL, VL and both element offsets in a single access, which is what a context switch needs.

Top module: `vl_ctrl`

## Requirements
- R1: After reset, the MVL CSR (select 0) reads XLEN-1, which means MVL = XLEN. The VL CSR (select 1) reads 1, both element offsets read 0, and wb_valid is low.
- R2: The MVL CSR holds an encoding e in its low FW = log2(XLEN) bits, and the effective MVL is e+1. A read returns e with all higher bits zero. A write keeps only the low FW bits of the write data.
- R3: A request with a nonzero destination and a length n, where 1 <= n <= MVL, sets VL to exactly n and returns n as the writeback value.
- R4: A request with a length above MVL sets VL to MVL and returns MVL.
- R5: A request with a length of 0 sets VL to 1 and returns 1.
- R6: A request whose destination index is 0 leaves VL unchanged and produces no writeback pulse.
- R7: For each accepted request, wb_valid is high for exactly the one cycle after the request. During that cycle, wb_rd carries the request's destination and wb_data carries the new VL, zero-extended.
- R8: A write that lowers MVL below the current VL also lowers VL to the new MVL. A write that leaves VL at or under the new MVL does not change VL.
- R9: The state CSR (select 2) packs fields from bit 0 in this order, each FW bits wide: MVL encoding, VL-1, destination offset, source offset. All higher bits are zero. A write loads all four fields, except that a VL field above the written MVL field is clamped to it.
- R10: When off_we is high, off_dst and off_src load the destination and source offsets. If a state CSR write occurs in the same cycle, the CSR write takes priority.
- R11: When a request and an MVL write (either through select 0 or select 2) occur in the same cycle, the request clamps against the newly written MVL. The request's result also takes priority over the VL field of the state write.
- R12: Writes to select 1 or select 3 change no state. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | CSR select: 0 MVL, 1 VL, 2 state, 3 unused |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for csr_sel (combinational) |
| req_valid | input | 1 | Set-length request strobe |
| req_len | input | XLEN | Requested vector length |
| req_rd | input | 5 | Destination register index |
| off_we | input | 1 | Element offset update strobe |
| off_dst | input | FW | New destination element offset |
| off_src | input | FW | New source element offset |
| wb_valid | output | 1 | Writeback pulse |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | XLEN | Writeback value (granted VL) |

## Verification
The hardest situation to reach is a collision: a set-length request arrives in the same cycle as an MVL or state write. In that case the request must clamp against the value being written, not the value currently stored. The stimulus creates this collision directly by driving the CSR write and the request on the same clock edge with a length above the new MVL, so that only the correct ordering returns the expected value. The MVL-lowering path is also checked from both sides. One write lowers MVL below VL and so trims VL. A later write raises MVL and must leave the trimmed VL alone.

// File: rtl/vl_ctrl.sv
module vl_ctrl #(
  parameter int XLEN = 32,
  localparam int FW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_len,
  input  logic [4:0]      req_rd,
  input  logic            off_we,
  input  logic [FW-1:0]   off_dst,
  input  logic [FW-1:0]   off_src,
  output logic            wb_valid,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data
);

  localparam logic [1:0] SEL_MVL = 2'd0;
  localparam logic [1:0] SEL_VL  = 2'd1;
  localparam logic [1:0] SEL_ST  = 2'd2;
  localparam int         PADW    = XLEN - 4*FW;

  initial begin
    if (XLEN != 32 && XLEN != 64) $error("vl_ctrl: XLEN must be 32 or 64");
  end

  logic [FW-1:0] mvl_q, vl_q, dst_q, src_q;
  logic [FW-1:0] mvl_nxt, vl_base, vl_lim, len_enc, vl_nxt;
  logic [FW:0]   mvl_eff_nxt, mvl_eff;
  logic          wr_mvl, wr_st, req_take;

  assign wr_mvl   = csr_we && (csr_sel == SEL_MVL);
  assign wr_st    = csr_we && (csr_sel == SEL_ST);
  assign req_take = req_valid && (req_rd != 5'd0);

  assign mvl_nxt     = (wr_mvl || wr_st) ? csr_wdata[FW-1:0] : mvl_q;
  assign mvl_eff_nxt = {1'b0, mvl_nxt} + 1'b1;
  assign mvl_eff     = {1'b0, mvl_q} + 1'b1;

  always_comb begin
    if (req_len == '0)
      len_enc = '0;
    else if (req_len > {{(XLEN-FW-1){1'b0}}, mvl_eff_nxt})
      len_enc = mvl_nxt;
    else
      len_enc = FW'(req_len - 1'b1);
  end

  assign vl_base = wr_st ? csr_wdata[2*FW-1:FW] : vl_q;
  assign vl_lim  = (vl_base > mvl_nxt) ? mvl_nxt : vl_base;
  assign vl_nxt  = req_take ? len_enc : vl_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mvl_q    <= FW'(XLEN - 1);
      vl_q     <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      wb_valid <= 1'b0;
      wb_rd    <= '0;
      wb_data  <= '0;
    end else begin
      mvl_q    <= mvl_nxt;
      vl_q     <= vl_nxt;
      wb_valid <= req_take;
      if (req_take) begin
        wb_rd   <= req_rd;
        wb_data <= XLEN'(len_enc) + 1'b1;
      end
      if (wr_st) begin
        dst_q <= csr_wdata[3*FW-1:2*FW];
        src_q <= csr_wdata[4*FW-1:3*FW];
      end else if (off_we) begin
        dst_q <= off_dst;
        src_q <= off_src;
      end
    end
  end

  always_comb begin
    case (csr_sel)
      SEL_MVL: csr_rdata = XLEN'(mvl_q);
      SEL_VL:  csr_rdata = XLEN'(vl_q) + 1'b1;
      SEL_ST:  csr_rdata = {{PADW{1'b0}}, src_q, dst_q, vl_q, mvl_q};
      default: csr_rdata = '0;
    endcase
  end

  AST_VL_WITHIN_MVL: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= mvl_q); // R4
  AST_X0_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd == 5'd0) |=> !wb_valid); // R6
  AST_X0_VL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd == 5'd0 && !csr_we) |=> $stable(vl_q)); // R6
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd != 5'd0) |=> (wb_valid && wb_rd == $past(req_rd))); // R7
  AST_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !wb_valid); // R7
  AST_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd != 5'd0 && !csr_we && req_len != '0 &&
     req_len <= XLEN'(mvl_eff)) |=> (wb_data == $past(req_len))); // R3
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd != 5'd0 && req_len == '0) |=> (wb_data == XLEN'(1))); // R5

endmodule

// File: tb/sim_vl_ctrl.sv
module sim_vl_ctrl;
  localparam int XL = 32;
  localparam int FW = 5;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int V_MVL [NV] = '{31, 31, 31, 7, 7, 0, 15, 3};
  localparam int V_LEN [NV] = '{5, 32, 40, 8, 9, 1, 0, 1000};
  localparam int V_RD  [NV] = '{1, 2, 3, 4, 5, 6, 7, 8};
  localparam int V_EXP [NV] = '{5, 32, 32, 8, 8, 1, 1, 4};

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 1'b0; logic [1:0] csr_sel = 2'd0;
  logic [XL-1:0] csr_wdata = '0, csr_rdata;
  logic req_valid = 1'b0; logic [XL-1:0] req_len = '0; logic [4:0] req_rd = '0;
  logic off_we = 1'b0; logic [FW-1:0] off_dst = '0, off_src = '0;
  logic wb_valid; logic [4:0] wb_rd; logic [XL-1:0] wb_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vl_ctrl #(.XLEN(XL)) u0 (.clk, .rst_n, .csr_we, .csr_sel, .csr_wdata, .csr_rdata,
    .req_valid, .req_len, .req_rd, .off_we, .off_dst, .off_src, .wb_valid, .wb_rd, .wb_data);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd_csr(input logic [1:0] sel, output logic [XL-1:0] v);
    csr_sel = sel; #1 v = csr_rdata;
  endtask

  task automatic wr_csr(input logic [1:0] sel, input logic [XL-1:0] d);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic do_req(input logic [XL-1:0] n, input logic [4:0] rd,
                        output logic v, output logic [4:0] r, output logic [XL-1:0] d);
    req_valid = 1'b1; req_len = n; req_rd = rd;
    @(negedge clk); v = wb_valid; r = wb_rd; d = wb_data; req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [XL-1:0] r, d; logic v; logic [4:0] ri;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 wb_valid", wb_valid, 0);
    rd_csr(2'd0, r); chk("R1 mvl", r, XL-1);
    rd_csr(2'd1, r); chk("R1 vl", r, 1);
    rd_csr(2'd2, r); chk("R1 offsets", r[4*FW-1:2*FW], 0);

    for (int i = 0; i < NV; i++) begin
      wr_csr(2'd0, XL'(V_MVL[i]));
      rd_csr(2'd0, r); chk("R2 mvl read", r, V_MVL[i]);
      do_req(XL'(V_LEN[i]), 5'(V_RD[i]), v, ri, d);
      chk("R7 wb_valid", v, 1);
      chk("R7 wb_rd", ri, V_RD[i]);
      chk(V_LEN[i] == 0 ? "R5 wb_data" : (V_LEN[i] > V_MVL[i] + 1 ? "R4 wb_data" : "R3 wb_data"), d, V_EXP[i]);
      rd_csr(2'd1, r); chk("R3 vl read", r, V_EXP[i]);
      @(negedge clk); chk("R7 pulse ends", wb_valid, 0);
    end

    wr_csr(2'd0, 32'hFFFF_FFE0 | 32'd19);
    rd_csr(2'd0, r); chk("R2 upper bits dropped", r, 19);

    do_req(32'd12, 5'd9, v, ri, d);
    @(negedge clk);
    do_req(32'd3, 5'd0, v, ri, d);
    chk("R6 no wb", v, 0);
    rd_csr(2'd1, r); chk("R6 vl held", r, 12);

    wr_csr(2'd0, 32'd7);
    rd_csr(2'd1, r); chk("R8 vl lowered", r, 8);
    wr_csr(2'd0, 32'd20);
    rd_csr(2'd1, r); chk("R8 vl kept", r, 8);

    wr_csr(2'd2, (32'd9 << 15) | (32'd7 << 10) | (32'd5 << 5) | 32'd12);
    rd_csr(2'd2, r); chk("R9 state read", r, (32'd9 << 15) | (32'd7 << 10) | (32'd5 << 5) | 32'd12);
    rd_csr(2'd1, r); chk("R9 vl from state", r, 6);
    wr_csr(2'd2, (32'd20 << 5) | 32'd12);
    rd_csr(2'd2, r); chk("R9 vl clamped", r[2*FW-1:FW], 12);

    off_we = 1'b1; off_dst = 5'd3; off_src = 5'd4;
    @(negedge clk); off_we = 1'b0;
    rd_csr(2'd2, r); chk("R10 offsets", r[4*FW-1:2*FW], {5'd4, 5'd3});
    off_we = 1'b1; off_dst = 5'd1; off_src = 5'd2;
    wr_csr(2'd2, (32'd11 << 15) | (32'd10 << 10) | 32'd12);
    off_we = 1'b0;
    rd_csr(2'd2, r); chk("R10 csr priority", r[4*FW-1:2*FW], {5'd11, 5'd10});

    csr_we = 1'b1; csr_sel = 2'd0; csr_wdata = 32'd3;
    do_req(32'd10, 5'd1, v, ri, d);
    csr_we = 1'b0;
    chk("R11 clamp to new mvl", d, 4);
    rd_csr(2'd1, r); chk("R11 vl", r, 4);
    csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = (32'd2 << 5) | 32'd9;
    do_req(32'd7, 5'd2, v, ri, d);
    csr_we = 1'b0;
    rd_csr(2'd1, r); chk("R11 request beats state vl", r, 7);

    wr_csr(2'd1, 32'd2);
    rd_csr(2'd1, r); chk("R12 vl write ignored", r, 7);
    wr_csr(2'd3, 32'hFFFF_FFFF);
    rd_csr(2'd3, r); chk("R12 sel3 zero", r, 0);
    rd_csr(2'd2, r); chk("R12 state untouched", r[2*FW-1:0], {5'd6, 5'd9});

    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd_csr(2'd1, r); chk("R1 vl after reset", r, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule